// File: doc/BRIEF.md
# Eight-Pin Bidirectional I/O Port with Peripheral Pin Arbitration

This block is an 8-bit general-purpose I/O port that sits on a microcontroller's register bus. Software owns three registers: a direction register, an output latch and a control register holding the shared weak pull-up enable. A fourth address returns the pad levels after a two-flop synchronizer. Each pin drives three signals toward its pad: output value, output enable and pull-up enable.

Other blocks can take pins away from the port. Each pin picks one owner in a fixed order. The upper byte of an external multiplexed address/data bus comes first, but only while that bus is not disabled. Enhanced PWM outputs come next, and the port latch comes last. Two configuration inputs change which pins PWM may use. One moves a group of PWM outputs off this port. The other lets pin 7 act as an alternate PWM output.

A parallel slave port controller can reuse pins 0 to 2 as control inputs. It receives their synchronized levels while its mode input is high. The direction bits are left alone in that mode, so software must set those pins to input itself. Per pin, ownership is an enumerated selection with three values: OWN_XBUS, OWN_PWM and OWN_PORT. The selection moves to OWN_XBUS when `xbus_off` falls. It moves to OWN_PWM when the bus is off and an eligible `pwm_oe` bit rises. It falls back to OWN_PORT when neither is active.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the latch reads 0x00, the direction register reads 0xFF and the pull-up enable reads 0. Every pad has output enable 0 and pull-up 0.
- R2: Register addresses are 0 = pin read, 1 = latch, 2 = direction and 3 = control (bit 0 = global pull-up enable). A write is visible on the first clock edge after the strobe. A write to address 0 or 1 loads the latch. Reading address 1 returns the latch value, not the pin level.
- R3: A port-owned pin has output enable equal to the inverse of its direction bit (1 = input), and it outputs its latch bit.
- R4: A pad's pull-up is on only when the global pull-up bit is 1 and that pad's output enable is 0.
- R5: While `xbus_off` is 0, every pin takes `xbus_oe` as its output enable and `xbus_out` as its value. Direction, latch and PWM have no effect on the pin.
- R6: While `xbus_off` is 1, an eligible pin with its `pwm_oe` bit set drives its `pwm_out` bit with output enable 1. With no other configuration, pins 0 to 6 are eligible.
- R7: When `cfg_pwm_remap` is 1, pins 0, 1, 4 and 5 are not eligible for PWM and fall back to the port.
- R8: Pin 7 is eligible for PWM only when `cfg_alt_pin` is 1.
- R9: Reading address 0 returns `pad_in` delayed by two clock edges, for every pin, whatever its direction.
- R10: When `psp_mode` is 1, `psp_ctl` carries synchronized pins 2:0; otherwise it is 0. The mode changes neither the direction register nor pin output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_pu | output | 8 | Pad weak pull-up enables |
| xbus_off | input | 1 | External bus disabled when 1 |
| xbus_oe | input | 1 | External bus drive enable |
| xbus_out | input | 8 | External bus upper byte |
| pwm_oe | input | 8 | PWM per-pin output requests |
| pwm_out | input | 8 | PWM per-pin values |
| cfg_pwm_remap | input | 1 | Moves PWM from pins 0,1,4,5 |
| cfg_alt_pin | input | 1 | Lets pin 7 carry PWM |
| psp_mode | input | 1 | Parallel slave port mode |
| psp_ctl | output | 3 | Synchronized control inputs for the slave port |

## Verification
The bench targets the points where priority and eligibility cross. One case enables the external bus while PWM requests are active; a wrong order would let PWM drive through the bus byte. Other cases remap PWM and toggle pin 7's option; mistakes here would drive the wrong pins. Further checks cover a pin that is driven while the pull-up bit is set, which a faulty design would both drive and pull up. The remaining checks cover latch readback against different pad levels (a faulty design echoes the pins), the exact two-edge synchronizer delay, and slave-port mode with output direction bits, which must keep driving.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    typedef enum logic [1:0] {
        OWN_PORT = 2'd0,
        OWN_PWM  = 2'd1,
        OWN_XBUS = 2'd2
    } owner_e;

    localparam logic [1:0] ADR_PINS = 2'd0;
    localparam logic [1:0] ADR_LAT  = 2'd1;
    localparam logic [1:0] ADR_DIR  = 2'd2;
    localparam logic [1:0] ADR_CTL  = 2'd3;
endpackage

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
    import gpio_mux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] dir_q,
    output logic         pu_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            dir_q <= '1;
            pu_q  <= 1'b0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                ADR_PINS, ADR_LAT: lat_q <= bus_wdata;
                ADR_DIR:           dir_q <= bus_wdata;
                ADR_CTL:           pu_q  <= bus_wdata[0];
                default:           lat_q <= lat_q;
            endcase
        end
    end

    assert_lat_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADR_LAT)) |=> (lat_q == $past(bus_wdata)));

    assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == ADR_DIR)) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_mux_pin.sv
module gpio_mux_pin
    import gpio_mux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xbus_act,
    input  logic xbus_oe,
    input  logic xbus_d,
    input  logic pwm_act,
    input  logic pwm_d,
    input  logic lat_d,
    input  logic dir_in,
    input  logic pu_glb,
    output logic pad_oe,
    output logic pad_o,
    output logic pad_pu
);
    owner_e owner;

    always_comb begin
        if (xbus_act)     owner = OWN_XBUS;
        else if (pwm_act) owner = OWN_PWM;
        else              owner = OWN_PORT;
    end

    always_comb begin
        unique case (owner)
            OWN_XBUS: begin pad_oe = xbus_oe; pad_o = xbus_d; end
            OWN_PWM:  begin pad_oe = 1'b1;    pad_o = pwm_d;  end
            OWN_PORT: begin pad_oe = ~dir_in; pad_o = lat_d;  end
            default:  begin pad_oe = 1'b0;    pad_o = 1'b0;   end
        endcase
    end

    assign pad_pu = pu_glb & ~pad_oe;

    assert_pu_off_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_pu && pad_oe));

    assert_xbus_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_act |-> (pad_oe == xbus_oe && pad_o == xbus_d));

    assert_pwm_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!xbus_act && pwm_act) |-> (pad_oe && pad_o == pwm_d));

    assert_port_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!xbus_act && !pwm_act) |-> (pad_oe == !dir_in && pad_o == lat_d));
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int           W          = 8,
    parameter logic [W-1:0] PWM_DFLT   = 8'h7F,
    parameter logic [W-1:0] PWM_REMAP  = 8'h33,
    parameter int           ALT_PIN    = 7,
    parameter int           PSP_W      = 3,
    parameter int           SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_pu,
    input  logic             xbus_off,
    input  logic             xbus_oe,
    input  logic [W-1:0]     xbus_out,
    input  logic [W-1:0]     pwm_oe,
    input  logic [W-1:0]     pwm_out,
    input  logic             cfg_pwm_remap,
    input  logic             cfg_alt_pin,
    input  logic             psp_mode,
    output logic [PSP_W-1:0] psp_ctl
);
    logic [W-1:0] lat_q, dir_q, pin_sync, pwm_ok;
    logic         pu_q;

    gpio_mux_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .lat_q(lat_q), .dir_q(dir_q), .pu_q(pu_q)
    );

    gpio_mux_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_sync(pin_sync)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == ALT_PIN) begin : g_alt
            assign pwm_ok[i] = cfg_alt_pin;
        end else begin : g_std
            assign pwm_ok[i] = PWM_DFLT[i] & ~(cfg_pwm_remap & PWM_REMAP[i]);
        end

        gpio_mux_pin u_pin (
            .clk(clk), .rst_n(rst_n),
            .xbus_act(~xbus_off), .xbus_oe(xbus_oe), .xbus_d(xbus_out[i]),
            .pwm_act(pwm_oe[i] & pwm_ok[i]), .pwm_d(pwm_out[i]),
            .lat_d(lat_q[i]), .dir_in(dir_q[i]), .pu_glb(pu_q),
            .pad_oe(pad_oe[i]), .pad_o(pad_out[i]), .pad_pu(pad_pu[i])
        );
    end

    always_comb begin
        unique case (bus_addr)
            ADR_PINS: bus_rdata = pin_sync;
            ADR_LAT:  bus_rdata = lat_q;
            ADR_DIR:  bus_rdata = dir_q;
            ADR_CTL:  bus_rdata = {{(W-1){1'b0}}, pu_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign psp_ctl = psp_mode ? pin_sync[PSP_W-1:0] : '0;

    assert_psp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !psp_mode |-> (psp_ctl == '0));
endmodule

// File: tb/tb_gpio_mux_port.sv
`timescale 1ns/1ps
module tb_gpio_mux_port;
    logic       clk = 0, rst_n = 0;
    logic       bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [7:0] pad_in = 0, pad_oe, pad_out, pad_pu;
    logic       xbus_off = 1, xbus_oe = 0;
    logic [7:0] xbus_out = 0, pwm_oe = 0, pwm_out = 0;
    logic       cfg_pwm_remap = 0, cfg_alt_pin = 0, psp_mode = 0;
    logic [2:0] psp_ctl;

    int checks = 0, errors = 0;
    logic [7:0] m_lat = 8'h00, m_dir = 8'hFF;
    logic       m_pu = 0;

    gpio_mux_port dut (.*);

    always #4 clk = ~clk;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        if (a == 2'd0 || a == 2'd1) m_lat = d;
        else if (a == 2'd2) m_dir = d;
        else m_pu = d[0];
    endtask

    task automatic rd_check(string tag, logic [1:0] a, logic [7:0] exp);
        bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    function automatic bit elig(int i);
        if (i == 7) return cfg_alt_pin;
        if (i == 0 || i == 1 || i == 4 || i == 5) return !cfg_pwm_remap;
        return 1'b1;
    endfunction

    task automatic check_pads();
        for (int i = 0; i < 8; i++) begin
            logic eo, ev;
            string tag;
            if (!xbus_off) begin eo = xbus_oe; ev = xbus_out[i]; tag = "R5 xbus"; end
            else if (pwm_oe[i] && elig(i)) begin
                eo = 1; ev = pwm_out[i];
                tag = (i == 7) ? "R8 alt pwm" : "R6 pwm";
            end else begin
                eo = !m_dir[i]; ev = m_lat[i];
                tag = (pwm_oe[i] && i == 7) ? "R8 pin7 port" :
                      (pwm_oe[i] && cfg_pwm_remap) ? "R7 remap port" : "R3 port";
            end
            check(tag, {7'd0, pad_oe[i]}, {7'd0, eo});
            if (eo) check(tag, {7'd0, pad_out[i]}, {7'd0, ev});
            check("R4 pullup", {7'd0, pad_pu[i]}, {7'd0, m_pu & ~eo});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd7715);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_check("R1 latch", 2'd1, 8'h00);
        rd_check("R1 dir", 2'd2, 8'hFF);
        rd_check("R1 ctl", 2'd3, 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pu", pad_pu, 8'h00);

        // R2 writes and latch readback vs pins
        wr(2'd1, 8'h5A);
        rd_check("R2 latch", 2'd1, 8'h5A);
        wr(2'd0, 8'hC3);
        rd_check("R2 addr0 to latch", 2'd1, 8'hC3);
        wr(2'd2, 8'h00);
        pad_in = 8'h3C;
        repeat (2) @(negedge clk);
        rd_check("R2 latch not pins", 2'd1, 8'hC3);
        rd_check("R9 pins while output", 2'd0, 8'h3C);
        check_pads();

        // R9 exact delay
        @(negedge clk); pad_in = 8'hA5;
        @(negedge clk); rd_check("R9 one edge old", 2'd0, 8'h3C);
        @(negedge clk); rd_check("R9 two edges new", 2'd0, 8'hA5);

        // R4 pull-up with mixed direction
        wr(2'd3, 8'h01);
        wr(2'd2, 8'hF0);
        check("R4 pu mixed", pad_pu, 8'hF0);

        // R5 bus overrides PWM and direction
        @(negedge clk);
        pwm_oe = 8'hFF; pwm_out = 8'h55; cfg_alt_pin = 1;
        xbus_off = 0; xbus_oe = 1; xbus_out = 8'h96; #1;
        check("R5 oe", pad_oe, 8'hFF);
        check("R5 out", pad_out, 8'h96);
        check("R4 pu bus drive", pad_pu, 8'h00);
        xbus_oe = 0; #1;
        check("R5 bus input", pad_oe, 8'h00);
        check_pads();

        // R6, R7, R8
        xbus_off = 1; cfg_alt_pin = 0; #1;
        check("R6 default pins", pad_oe, 8'hFF & {~m_dir[7], 7'h7F});
        cfg_pwm_remap = 1; #1; check_pads();
        cfg_alt_pin = 1; #1; check("R8 pin7 pwm", {7'd0, pad_oe[7]}, 8'h01);
        check_pads();

        // R10 slave-port mode
        @(negedge clk);
        pwm_oe = 0; cfg_pwm_remap = 0; cfg_alt_pin = 0;
        wr(2'd2, 8'h00);
        pad_in = 8'h05;
        psp_mode = 1;
        repeat (3) @(negedge clk);
        check("R10 psp ctl", {5'd0, psp_ctl}, 8'h05);
        rd_check("R10 dir untouched", 2'd2, 8'h00);
        check("R10 pins still driven", pad_oe, 8'hFF);
        psp_mode = 0; #1;
        check("R10 psp idle", {5'd0, psp_ctl}, 8'h00);

        // random mix
        for (int n = 0; n < 300; n++) begin
            wr(2'($urandom_range(1, 3)), 8'($urandom));
            @(negedge clk);
            xbus_off = ($urandom_range(0, 3) != 0);
            xbus_oe = 1'($urandom); xbus_out = 8'($urandom);
            pwm_oe = 8'($urandom); pwm_out = 8'($urandom);
            cfg_pwm_remap = 1'($urandom); cfg_alt_pin = 1'($urandom);
            psp_mode = 1'($urandom); pad_in = 8'($urandom);
            #1;
            check_pads();
            rd_check("R2 latch rand", 2'd1, m_lat);
            rd_check("R2 dir rand", 2'd2, m_dir);
            repeat (2) @(negedge clk);
            rd_check("R9 pins rand", 2'd0, pad_in);
            check("R10 psp rand", {5'd0, psp_ctl}, psp_mode ? {5'd0, pad_in[2:0]} : 8'h00);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule